// File: doc/BRIEF.md
# DMA Channel Completion and Linking Controller

This block keeps the status and end-of-loop state for every channel of a multi-channel DMA engine. For each channel it holds a busy flag, a finished flag and an error flag. It also holds a countdown of remaining major iterations, a link-enable bit with a 6-bit link-target index, a descriptor-reload enable, and a reload pointer. The data-moving engine reports three things for the channel it is working on: that service has begun, that a minor loop has ended, or that a fault was seen.

When a minor loop ends with the countdown at one, the major loop is finished. The block then does up to two things. It can pulse the start-set line of another channel so that channel requests service. It can also issue a request to fetch the next 32-byte descriptor for the finishing channel from a 32-byte-aligned address. If both are enabled, the fetch request goes out first and the start-set pulse follows one cycle later.

Software writes the configuration through a simple write port. Writes that would turn on linking or reload while the channel's finished flag is set are stored as zero, so the sequence of reading the flag and then arming the channel stays safe.

Top module: `dma_chan_ctrl`

## Requirements
- R1: An engine service-start event sets the channel's busy flag after the next clock edge. A minor-loop-end event or a fault event clears it, and clearing wins if both arrive together.
- R2: A minor-loop-end event without a fault decrements a nonzero countdown by one. When the countdown goes from 1 to 0, the finished flag is set on the same edge.
- R3: A service-start event clears the finished flag, and so does a control write (field code 3) with data bit 0 set. A major-loop completion on the same edge wins over either clear.
- R4: At a completion with linking enabled, start_set_o pulses for one cycle at bit index link target. The link target is taken from data bits 13:8 of a configuration write. A target not below NUM_CH produces no pulse.
- R5: At a completion with linking disabled, no start-set pulse is produced for that channel.
- R6: A configuration write (field code 0; bit 0 enables linking, bit 1 enables reload) stores both enable bits as zero when the channel's finished flag is set before that edge. The link target is stored either way.
- R7: At a completion with reload enabled and pointer bits 4:0 all zero, fetch_req_o pulses for one cycle. fetch_addr_o then carries the pointer and fetch_ch_o the channel. The pointer is written with field code 2.
- R8: At a completion with reload enabled and any of pointer bits 4:0 set, the error flag is set, and neither a fetch nor a start-set pulse is produced. The finished flag is still set.
- R9: A fault event clears the busy flag and sets the error flag. It leaves the countdown unchanged and blocks completion even when a minor-loop-end arrives on the same edge. A control write with data bit 1 set clears the error flag, but a fault on the same edge wins.
- R10: When linking and reload are both enabled at a completion, fetch_req_o pulses on the cycle after the completing edge. The start-set pulse comes one cycle later.
- R11: A write with field code 1 loads the countdown from the low ITER_W data bits and takes precedence over a decrement on the same edge. rd_citer_o shows the countdown of channel rd_ch combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_ch | input | SEL_W | Channel addressed by the write |
| wr_field | input | 2 | Field code: 0 config, 1 countdown, 2 pointer, 3 control |
| wr_data | input | ADDR_W | Write data |
| eng_ch | input | SEL_W | Channel the engine reports on |
| ev_start | input | 1 | Service has begun |
| ev_minor | input | 1 | Minor loop ended |
| ev_err | input | 1 | Fault detected |
| rd_ch | input | SEL_W | Channel whose countdown is shown |
| rd_citer_o | output | ITER_W | Countdown of channel rd_ch |
| active_o | output | NUM_CH | Busy flags |
| done_o | output | NUM_CH | Finished flags |
| err_o | output | NUM_CH | Error flags |
| link_en_o | output | NUM_CH | Stored link enables |
| sg_en_o | output | NUM_CH | Stored reload enables |
| start_set_o | output | NUM_CH | One-cycle start-set pulses to channels |
| fetch_req_o | output | 1 | Descriptor fetch request pulse |
| fetch_addr_o | output | ADDR_W | Descriptor address |
| fetch_ch_o | output | SEL_W | Channel to reload |

## Verification
All flags, enables, the countdown and the fetch request change on the clock edge that samples the causing input, so they are due one cycle after the stimulus. A start-set pulse is due in that same cycle, or one cycle later when a reload is also issued. The countdown readback is combinational in rd_ch. The reference model advances on the same edge as the design and holds its pending link for one extra edge. Outputs are compared at the falling edge, with inputs changed just after the rising edge, so each result is sampled in the cycle in which it is due.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    F_CFG  = 2'd0,
    F_ITER = 2'd1,
    F_SGA  = 2'd2,
    F_CTRL = 2'd3
  } dcc_field_e;

  localparam int LINK_W       = 6;
  localparam int ALIGN_BITS   = 5;
  localparam int CFG_LINK_BIT = 0;
  localparam int CFG_SG_BIT   = 1;
  localparam int CFG_TGT_LO   = 8;
  localparam int CTRL_DONE_BIT = 0;
  localparam int CTRL_ERR_BIT  = 1;
endpackage

// File: rtl/dcc_chan.sv
module dcc_chan
  import dcc_pkg::*;
#(
  parameter int ITER_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  dcc_field_e        wr_field,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              ev_start,
  input  logic              ev_minor,
  input  logic              ev_err,
  input  logic              ev_align,
  output logic              active_o,
  output logic              done_o,
  output logic              err_o,
  output logic              link_en_o,
  output logic              sg_en_o,
  output logic [LINK_W-1:0] link_ch_o,
  output logic [ITER_W-1:0] citer_o,
  output logic [ADDR_W-1:0] sga_o,
  output logic              major_end_o
);
  logic              active_q, active_n;
  logic              done_q, done_n;
  logic              err_q, err_n;
  logic              link_en_q, link_en_n;
  logic              sg_en_q, sg_en_n;
  logic [LINK_W-1:0] link_ch_q, link_ch_n;
  logic [ITER_W-1:0] citer_q, citer_n;
  logic [ADDR_W-1:0] sga_q;
  logic              wr_cfg, wr_iter, wr_sga, wr_ctrl;
  logic              count_step;

  always_comb begin
    wr_cfg  = wr_hit && (wr_field == F_CFG);
    wr_iter = wr_hit && (wr_field == F_ITER);
    wr_sga  = wr_hit && (wr_field == F_SGA);
    wr_ctrl = wr_hit && (wr_field == F_CTRL);

    count_step  = ev_minor && !ev_err && (citer_q != '0);
    major_end_o = ev_minor && !ev_err && (citer_q == ITER_W'(1));

    active_n = active_q;
    if (ev_start)            active_n = 1'b1;
    if (ev_minor || ev_err)  active_n = 1'b0;

    citer_n = citer_q;
    if (count_step) citer_n = citer_q - ITER_W'(1);
    if (wr_iter)    citer_n = wr_data[ITER_W-1:0];

    done_n = done_q;
    if (ev_start)                           done_n = 1'b0;
    if (wr_ctrl && wr_data[CTRL_DONE_BIT])  done_n = 1'b0;
    if (major_end_o)                        done_n = 1'b1;

    err_n = err_q;
    if (wr_ctrl && wr_data[CTRL_ERR_BIT])   err_n = 1'b0;
    if (ev_err || ev_align)                 err_n = 1'b1;

    link_en_n = wr_data[CFG_LINK_BIT] && !done_q;
    sg_en_n   = wr_data[CFG_SG_BIT]   && !done_q;
    link_ch_n = wr_data[CFG_TGT_LO +: LINK_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      link_en_q <= 1'b0;
      sg_en_q   <= 1'b0;
      link_ch_q <= '0;
      citer_q   <= '0;
      sga_q     <= '0;
    end else begin
      active_q <= active_n;
      done_q   <= done_n;
      err_q    <= err_n;
      citer_q  <= citer_n;
      if (wr_cfg) begin
        link_en_q <= link_en_n;
        sg_en_q   <= sg_en_n;
        link_ch_q <= link_ch_n;
      end
      if (wr_sga) sga_q <= wr_data;
    end
  end

  assign active_o  = active_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign link_en_o = link_en_q;
  assign sg_en_o   = sg_en_q;
  assign link_ch_o = link_ch_q;
  assign citer_o   = citer_q;
  assign sga_o     = sga_q;
endmodule

// File: rtl/dcc_finish.sv
module dcc_finish
  import dcc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              major_end,
  input  logic [SEL_W-1:0]  ch_sel,
  input  logic              link_en,
  input  logic              sg_en,
  input  logic [LINK_W-1:0] link_ch,
  input  logic [ADDR_W-1:0] sga,
  output logic              align_err_o,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [SEL_W-1:0]  fetch_ch_o,
  output logic [NUM_CH-1:0] start_set_o
);
  logic              ptr_bad, do_fetch, do_link;
  logic [NUM_CH-1:0] tgt_vec;
  logic [NUM_CH-1:0] pend_q, pend_n;
  logic [NUM_CH-1:0] start_q, start_n;
  logic              fetch_q;
  logic [ADDR_W-1:0] faddr_q;
  logic [SEL_W-1:0]  fch_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_tgt
    assign tgt_vec[i] = (link_ch == LINK_W'(i));
  end

  always_comb begin
    ptr_bad     = sg_en && (sga[ALIGN_BITS-1:0] != '0);
    align_err_o = major_end && ptr_bad;
    do_fetch    = major_end && sg_en && !ptr_bad;
    do_link     = major_end && link_en && !ptr_bad;
    pend_n      = (do_link && sg_en) ? tgt_vec : '0;
    start_n     = pend_q | ((do_link && !sg_en) ? tgt_vec : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      start_q <= '0;
      fetch_q <= 1'b0;
      faddr_q <= '0;
      fch_q   <= '0;
    end else begin
      pend_q  <= pend_n;
      start_q <= start_n;
      fetch_q <= do_fetch;
      if (do_fetch) begin
        faddr_q <= sga;
        fch_q   <= ch_sel;
      end
    end
  end

  assign fetch_req_o  = fetch_q;
  assign fetch_addr_o = faddr_q;
  assign fetch_ch_o   = fch_q;
  assign start_set_o  = start_q;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dcc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ITER_W = 16,
  parameter int ADDR_W = 32,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_ch,
  input  logic [1:0]        wr_field,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  eng_ch,
  input  logic              ev_start,
  input  logic              ev_minor,
  input  logic              ev_err,
  input  logic [SEL_W-1:0]  rd_ch,
  output logic [ITER_W-1:0] rd_citer_o,
  output logic [NUM_CH-1:0] active_o,
  output logic [NUM_CH-1:0] done_o,
  output logic [NUM_CH-1:0] err_o,
  output logic [NUM_CH-1:0] link_en_o,
  output logic [NUM_CH-1:0] sg_en_o,
  output logic [NUM_CH-1:0] start_set_o,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [SEL_W-1:0]  fetch_ch_o
);
  dcc_field_e        field;
  logic [NUM_CH-1:0] major_v;
  logic [LINK_W-1:0] link_ch_a [NUM_CH];
  logic [ITER_W-1:0] citer_a   [NUM_CH];
  logic [ADDR_W-1:0] sga_a     [NUM_CH];
  logic              fin_major, fin_align;

  assign field = dcc_field_e'(wr_field);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit_w, hit_e;
    assign hit_w = wr_en && (wr_ch == SEL_W'(i));
    assign hit_e = (eng_ch == SEL_W'(i));

    dcc_chan #(.ITER_W(ITER_W), .ADDR_W(ADDR_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hit     (hit_w),
      .wr_field   (field),
      .wr_data    (wr_data),
      .ev_start   (ev_start && hit_e),
      .ev_minor   (ev_minor && hit_e),
      .ev_err     (ev_err && hit_e),
      .ev_align   (fin_align && hit_e),
      .active_o   (active_o[i]),
      .done_o     (done_o[i]),
      .err_o      (err_o[i]),
      .link_en_o  (link_en_o[i]),
      .sg_en_o    (sg_en_o[i]),
      .link_ch_o  (link_ch_a[i]),
      .citer_o    (citer_a[i]),
      .sga_o      (sga_a[i]),
      .major_end_o(major_v[i])
    );
  end

  assign fin_major  = |major_v;
  assign rd_citer_o = citer_a[rd_ch];

  dcc_finish #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_finish (
    .clk         (clk),
    .rst_n       (rst_n),
    .major_end   (fin_major),
    .ch_sel      (eng_ch),
    .link_en     (link_en_o[eng_ch]),
    .sg_en       (sg_en_o[eng_ch]),
    .link_ch     (link_ch_a[eng_ch]),
    .sga         (sga_a[eng_ch]),
    .align_err_o (fin_align),
    .fetch_req_o (fetch_req_o),
    .fetch_addr_o(fetch_addr_o),
    .fetch_ch_o  (fetch_ch_o),
    .start_set_o (start_set_o)
  );
endmodule

// File: rtl/dcc_chk.sv
module dcc_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_ch,
  input logic [1:0]        wr_field,
  input logic [SEL_W-1:0]  eng_ch,
  input logic              ev_start,
  input logic              ev_minor,
  input logic              ev_err,
  input logic [NUM_CH-1:0] active_o,
  input logic [NUM_CH-1:0] done_o,
  input logic [NUM_CH-1:0] err_o,
  input logic [NUM_CH-1:0] link_en_o,
  input logic [NUM_CH-1:0] sg_en_o,
  input logic              fetch_req_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              fin_align
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !ev_minor && !ev_err) |=> active_o[$past(eng_ch)]); // R1
  AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_minor || ev_err) |=> !active_o[$past(eng_ch)]); // R1
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !ev_minor) |=> !done_o[$past(eng_ch)]); // R3
  AST_DONE_MASKS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_field == 2'd0 && done_o[wr_ch]) |=>
      (!link_en_o[$past(wr_ch)] && !sg_en_o[$past(wr_ch)])); // R6
  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |-> (fetch_addr_o[4:0] == 5'd0)); // R7
  AST_MISALIGN_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    fin_align |=> !fetch_req_o); // R8
  AST_FAULT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> err_o[$past(eng_ch)]); // R9
endmodule

bind dma_chan_ctrl dcc_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_ch       (wr_ch),
  .wr_field    (wr_field),
  .eng_ch      (eng_ch),
  .ev_start    (ev_start),
  .ev_minor    (ev_minor),
  .ev_err      (ev_err),
  .active_o    (active_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .link_en_o   (link_en_o),
  .sg_en_o     (sg_en_o),
  .fetch_req_o (fetch_req_o),
  .fetch_addr_o(fetch_addr_o),
  .fin_align   (fin_align)
);

// File: tb/dma_chan_ctrl_tb_top.sv
module dma_chan_ctrl_tb_top;
  localparam int NUM_CH = 8;
  localparam int ITER_W = 16;
  localparam int ADDR_W = 32;
  localparam int SEL_W  = $clog2(NUM_CH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [SEL_W-1:0]  wr_ch = '0;
  logic [1:0]        wr_field = '0;
  logic [ADDR_W-1:0] wr_data = '0;
  logic [SEL_W-1:0]  eng_ch = '0;
  logic              ev_start = 1'b0, ev_minor = 1'b0, ev_err = 1'b0;
  logic [SEL_W-1:0]  rd_ch = '0;
  logic [ITER_W-1:0] rd_citer_o;
  logic [NUM_CH-1:0] active_o, done_o, err_o, link_en_o, sg_en_o, start_set_o;
  logic              fetch_req_o;
  logic [ADDR_W-1:0] fetch_addr_o;
  logic [SEL_W-1:0]  fetch_ch_o;

  always #4 clk = ~clk;

  dma_chan_ctrl #(.NUM_CH(NUM_CH), .ITER_W(ITER_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_field(wr_field),
    .wr_data(wr_data), .eng_ch(eng_ch), .ev_start(ev_start), .ev_minor(ev_minor),
    .ev_err(ev_err), .rd_ch(rd_ch), .rd_citer_o(rd_citer_o), .active_o(active_o),
    .done_o(done_o), .err_o(err_o), .link_en_o(link_en_o), .sg_en_o(sg_en_o),
    .start_set_o(start_set_o), .fetch_req_o(fetch_req_o),
    .fetch_addr_o(fetch_addr_o), .fetch_ch_o(fetch_ch_o)
  );

  // reference model state
  logic [NUM_CH-1:0] m_act = '0, m_done = '0, m_err = '0, m_len = '0, m_sen = '0;
  logic [NUM_CH-1:0] m_start = '0, m_pend = '0;
  logic [5:0]        m_tgt   [NUM_CH];
  logic [ITER_W-1:0] m_cnt   [NUM_CH];
  logic [ADDR_W-1:0] m_ptr   [NUM_CH];
  logic              m_freq = 1'b0;
  logic [ADDR_W-1:0] m_faddr = '0;
  logic [SEL_W-1:0]  m_fch = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = '0; m_done = '0; m_err = '0; m_len = '0; m_sen = '0;
      m_start = '0; m_pend = '0; m_freq = 1'b0; m_faddr = '0; m_fch = '0;
      for (int i = 0; i < NUM_CH; i++) begin
        m_tgt[i] = '0; m_cnt[i] = '0; m_ptr[i] = '0;
      end
    end else begin
      int c;
      bit fin, bad, lnk;
      c   = int'(eng_ch);
      fin = ev_minor && !ev_err && (m_cnt[c] == 1);
      bad = m_sen[c] && (m_ptr[c][4:0] != 0);
      lnk = fin && m_len[c] && !bad && (int'(m_tgt[c]) < NUM_CH);
      m_start = m_pend;
      m_pend  = '0;
      if (lnk) begin
        if (m_sen[c]) m_pend[m_tgt[c]] = 1'b1;
        else          m_start[m_tgt[c]] = 1'b1;
      end
      m_freq = fin && m_sen[c] && !bad;
      if (m_freq) begin m_faddr = m_ptr[c]; m_fch = eng_ch; end
      if (wr_en && wr_field == 2'd0) begin
        m_len[wr_ch] = wr_data[0] && !m_done[wr_ch];
        m_sen[wr_ch] = wr_data[1] && !m_done[wr_ch];
        m_tgt[wr_ch] = wr_data[13:8];
      end
      if (ev_start) begin m_act[c] = 1'b1; m_done[c] = 1'b0; end
      if (ev_minor || ev_err) m_act[c] = 1'b0;
      if (ev_minor && !ev_err && m_cnt[c] != 0) m_cnt[c] = m_cnt[c] - 1;
      if (wr_en && wr_field == 2'd3) begin
        if (wr_data[0]) m_done[wr_ch] = 1'b0;
        if (wr_data[1]) m_err[wr_ch]  = 1'b0;
      end
      if (fin) m_done[c] = 1'b1;
      if (ev_err || (fin && bad)) m_err[c] = 1'b1;
      if (wr_en && wr_field == 2'd1) m_cnt[wr_ch] = wr_data[ITER_W-1:0];
      if (wr_en && wr_field == 2'd2) m_ptr[wr_ch] = wr_data;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("R1 busy flags", 64'(active_o), 64'(m_act));
      chk("R2 R3 finished flags", 64'(done_o), 64'(m_done));
      chk("R8 R9 error flags", 64'(err_o), 64'(m_err));
      chk("R6 link enables", 64'(link_en_o), 64'(m_len));
      chk("R6 reload enables", 64'(sg_en_o), 64'(m_sen));
      chk("R4 R5 R10 start-set", 64'(start_set_o), 64'(m_start));
      chk("R7 R8 R10 fetch request", 64'(fetch_req_o), 64'(m_freq));
      chk("R7 fetch address", 64'(fetch_addr_o), 64'(m_faddr));
      chk("R7 fetch channel", 64'(fetch_ch_o), 64'(m_fch));
      chk("R2 R11 countdown readback", 64'(rd_citer_o), 64'(m_cnt[rd_ch]));
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    wr_en = 1'b0; ev_start = 1'b0; ev_minor = 1'b0; ev_err = 1'b0;
  endtask

  task automatic wr(input int ch, input int fld, input logic [ADDR_W-1:0] d);
    wr_en = 1'b1; wr_ch = SEL_W'(ch); wr_field = 2'(fld); wr_data = d;
    tick();
  endtask

  task automatic ev(input int ch, input bit s, input bit m, input bit e);
    eng_ch = SEL_W'(ch); ev_start = s; ev_minor = m; ev_err = e; rd_ch = SEL_W'(ch);
    tick();
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R4: link from ch1 to ch3 after two iterations
    wr(1, 0, 32'h0000_0301); wr(1, 1, 32'd2);
    ev(1, 1, 0, 0); ev(1, 0, 1, 0); ev(1, 1, 0, 0); ev(1, 0, 1, 0); tick(); tick();
    // R10 R7: reload plus link, ch2 to ch5
    wr(2, 2, 32'h0000_0100); wr(2, 0, 32'h0000_0503); wr(2, 1, 32'd1);
    ev(2, 1, 0, 0); ev(2, 0, 1, 0); tick(); tick();
    // R6: ch2 finished, arming is masked; then clear and arm
    wr(2, 0, 32'h0000_0403); tick();
    wr(2, 3, 32'd1); wr(2, 0, 32'h0000_0403); tick();
    // R8: misaligned pointer on ch4
    wr(4, 2, 32'h0000_0104); wr(4, 0, 32'h0000_0003); wr(4, 1, 32'd1);
    ev(4, 1, 0, 0); ev(4, 0, 1, 0); tick(); wr(4, 3, 32'd2);
    // R9: fault together with minor end on ch5
    wr(5, 1, 32'd3); ev(5, 1, 0, 0); ev(5, 0, 1, 1); tick();
    // R5: no link; R4 target out of range
    wr(6, 0, 32'h0000_0700); wr(6, 1, 32'd1); ev(6, 1, 0, 0); ev(6, 0, 1, 0);
    wr(7, 0, 32'h0000_0901); wr(7, 1, 32'd1); ev(7, 1, 0, 0); ev(7, 0, 1, 0); tick();
    // R11: countdown write beats decrement on the same edge
    wr(3, 1, 32'd5); ev(3, 1, 0, 0);
    eng_ch = 3'd3; ev_minor = 1'b1; wr(3, 1, 32'd9);
    // random phase
    for (int k = 0; k < 4000; k++) begin
      int f, sel;
      rd_ch = SEL_W'($urandom_range(0, NUM_CH - 1));
      if ($urandom_range(0, 9) < 3) begin
        wr_en = 1'b1;
        wr_ch = SEL_W'($urandom_range(0, NUM_CH - 1));
        f = $urandom_range(0, 3);
        wr_field = 2'(f);
        case (f)
          0: wr_data = {18'd0, 6'($urandom_range(0, 9)), 6'd0, 2'($urandom_range(0, 3))};
          1: wr_data = 32'($urandom_range(0, 3));
          2: wr_data = ($urandom_range(0, 3) == 0) ? 32'($urandom) : {$urandom_range(0, 255), 5'd0};
          default: wr_data = 32'($urandom_range(0, 3));
        endcase
      end
      eng_ch = SEL_W'($urandom_range(0, NUM_CH - 1));
      sel = $urandom_range(0, 9);
      ev_start = (sel < 3);
      ev_minor = (sel >= 3 && sel < 7) || sel == 8;
      ev_err   = (sel == 7) || (sel == 8);
      tick();
    end
    tick(); tick();
    finished = 1;
    report();
    $finish;
  end
endmodule